// File: doc/BRIEF.md
# Indirect Lookup Table Access Port

This block holds a forwarding table whose entries are 68 bits wide, wider than the 32-bit register bus that software uses to reach them. Software never addresses an entry directly. It fills three 32-bit staging word registers and then writes a table control register. With bit 31 set, the write commits the staged words into the entry named by the index. With bit 31 clear, the write copies the named entry back into the staging words, so the next bus reads return it.

The word order is reversed with respect to entry bits. Entry bit n sits in word (2 - n/32) at bit n mod 32. Word 2 carries the low 32 bits, word 1 the middle 32, and word 0 only the top four. The block gives no meaning to any entry field. The field positions are listed below only because the words must deliver them intact to the lookup, learning and aging logic elsewhere.

That other logic uses a second, internal port that reads and writes whole entries in one cycle. When this port and a bus table operation meet in the same cycle, the internal port wins and the bus is stalled.

Top module: `lut_access_port`

## Requirements
- R1: After reset every table entry reads as all zeros, which is type free (entry bits 61:60 = 0), and all three staging words read zero.
- R2: A bus write at offset 0x34, 0x38 or 0x3C loads staging word 0, 1 or 2, and a read at the same offset returns it on the same cycle. Word 0 keeps only its low 4 bits, and its bits 31:4 read zero.
- R3: A bus write at offset 0x20 with bit 31 set stores {word0[3:0], word1, word2} into the entry indexed by bits 30:0 of the written value, so that entry bit n equals bit (n mod 32) of word (2 - n/32).
- R4: A bus write at offset 0x20 with bit 31 clear loads the indexed entry into the staging words by the next clock edge: word 0 gets entry bits 67:64, word 1 gets bits 63:32, word 2 gets bits 31:0.
- R5: Entry fields pass through the words unchanged. Port number 67:66 and secure 64 land in word 0 bits 3:2 and 0. Ucast type 63:62, entry type 61:60, VLAN ID 59:48 and the first two address bytes 47:32 land in word 1 bits 31:30, 29:28, 27:16 and 15:0. The multicast flag, bit 40, lands in word 1 bit 8. The last four address bytes land in word 2.
- R6: An index at or beyond DEPTH is ignored by a commit, and no entry changes. A load with such an index sets all three staging words to zero. On the internal port, such an index reads as zero and a write to it is ignored.
- R7: When an internal request and a bus table operation occur in the same cycle, the internal request is served and reg_ready is low for that cycle. The bus operation completes on the first cycle without an internal request. Word register accesses never stall.
- R8: A commit changes no entry other than the indexed one. Writes to unmapped offsets change nothing, and reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bus write strobe, held until reg_ready |
| reg_rd | input | 1 | Bus read strobe |
| reg_addr | input | 8 | Bus byte offset |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data, same cycle |
| reg_ready | output | 1 | Low when a bus table operation is stalled |
| eng_req | input | 1 | Internal port request, always granted |
| eng_we | input | 1 | Internal port write (1) or read (0) |
| eng_idx | input | AW+1 | Internal port entry index |
| eng_wentry | input | 68 | Internal port write entry |
| eng_rentry | output | 68 | Entry at eng_idx, zero if out of range |

## Verification
Commits are tried with distinct patterns across all three words, including an all-ones word 0. These show whether word order is reversed and whether word 0 is truncated correctly. A structured entry with a distinct value in every field is written on the internal port and read over the bus, which separates a field misplacement from a word swap. Out-of-range indices, a same-cycle collision with the internal port, and unmapped offsets tell apart index wrap-around, lost bus operations and stray writes.

// File: rtl/lut_access_port.sv
module lut_access_port #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 68,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TOP_W  = ENTRY_W - 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_ready,
  input  logic               eng_req,
  input  logic               eng_we,
  input  logic [AW:0]        eng_idx,
  input  logic [ENTRY_W-1:0] eng_wentry,
  output logic [ENTRY_W-1:0] eng_rentry
);
  localparam logic [7:0] OFS_CTL = 8'h20;
  localparam logic [7:0] OFS_W0  = 8'h34;
  localparam logic [7:0] OFS_W1  = 8'h38;
  localparam logic [7:0] OFS_W2  = 8'h3C;

  logic [ENTRY_W-1:0] tbl [DEPTH];
  logic [TOP_W-1:0]   w0;
  logic [31:0]        w1, w2;

  logic               tbl_op, bus_go, bus_inr, eng_inr;
  logic               bus_commit, bus_load, eng_write;
  logic [AW-1:0]      bus_slot, eng_slot;
  logic [ENTRY_W-1:0] bus_entry, staged;

  assign tbl_op     = reg_wr && (reg_addr == OFS_CTL);
  assign reg_ready  = !(tbl_op && eng_req);
  assign bus_go     = tbl_op && !eng_req;
  assign bus_inr    = reg_wdata[30:0] < 31'(DEPTH);
  assign eng_inr    = {1'b0, eng_idx} < (AW + 2)'(DEPTH);
  assign bus_slot   = reg_wdata[AW-1:0];
  assign eng_slot   = eng_idx[AW-1:0];
  assign bus_commit = bus_go && reg_wdata[31] && bus_inr;
  assign bus_load   = bus_go && !reg_wdata[31];
  assign eng_write  = eng_req && eng_we && eng_inr;
  assign staged     = {w0, w1, w2};
  assign bus_entry  = bus_inr ? tbl[bus_slot] : '0;
  assign eng_rentry = eng_inr ? tbl[eng_slot] : '0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        tbl[i] <= '0;
      else if (eng_write && eng_slot == AW'(i))
        tbl[i] <= eng_wentry;
      else if (bus_commit && bus_slot == AW'(i))
        tbl[i] <= staged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
    end else if (bus_load) begin
      w0 <= bus_entry[ENTRY_W-1:64];
      w1 <= bus_entry[63:32];
      w2 <= bus_entry[31:0];
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_W0:  w0 <= reg_wdata[TOP_W-1:0];
        OFS_W1:  w1 <= reg_wdata;
        OFS_W2:  w2 <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_W0:  reg_rdata = {{(32-TOP_W){1'b0}}, w0};
        OFS_W1:  reg_rdata = w1;
        OFS_W2:  reg_rdata = w2;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lut_access_port_chk.sv
module lut_access_port_chk #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 68,
  parameter int AW      = 6,
  parameter int TOP_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [7:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic               reg_ready,
  input logic               eng_req,
  input logic [AW:0]        eng_idx,
  input logic [ENTRY_W-1:0] eng_rentry,
  input logic [TOP_W-1:0]   w0,
  input logic [31:0]        w1,
  input logic [31:0]        w2
);
  a_r7_engine_stalls_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h20 && eng_req) |-> !reg_ready);

  a_r7_words_never_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 8'h20) |-> reg_ready);

  a_r2_word0_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h34) |-> (reg_rdata[31:TOP_W] == '0));

  a_r2_word2_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h3C) |=> (w2 == $past(reg_wdata)));

  a_r6_oob_engine_read: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, eng_idx} >= (AW + 2)'(DEPTH)) |-> (eng_rentry == '0));

  a_r6_oob_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h20 && reg_ready && !reg_wdata[31] &&
     reg_wdata[30:0] >= 31'(DEPTH)) |=> (w0 == '0 && w1 == '0 && w2 == '0));

  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != 8'h34 && reg_addr != 8'h38 && reg_addr != 8'h3C)
      |-> (reg_rdata == '0));
endmodule

bind lut_access_port lut_access_port_chk #(
  .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .AW(AW), .TOP_W(TOP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_ready(reg_ready), .eng_req(eng_req), .eng_idx(eng_idx),
  .eng_rentry(eng_rentry), .w0(w0), .w1(w1), .w2(w2)
);

// File: tb/sim_lut_access_port.sv
module sim_lut_access_port;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        reg_ready;
  logic        eng_req = 0, eng_we = 0;
  logic [AW:0] eng_idx = 0;
  logic [67:0] eng_wentry = 0, eng_rentry;

  int checks = 0, fails = 0;
  bit done = 0;

  lut_access_port #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .eng_req(eng_req), .eng_we(eng_we),
    .eng_idx(eng_idx), .eng_wentry(eng_wentry), .eng_rentry(eng_rentry)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [67:0] got, input logic [67:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    logic rdy;
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    do begin
      #1 rdy = reg_ready;
      @(posedge clk);
      if (!rdy) @(negedge clk);
    end while (!rdy);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic eng_wr(input int idx, input logic [67:0] v);
    @(negedge clk);
    eng_req = 1; eng_we = 1; eng_idx = (AW+1)'(idx); eng_wentry = v;
    @(posedge clk);
    #1 eng_req = 0; eng_we = 0;
  endtask

  task automatic eng_rd(input int idx, output logic [67:0] v);
    @(negedge clk);
    eng_req = 1; eng_we = 0; eng_idx = (AW+1)'(idx);
    #1 v = eng_rentry;
    eng_req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [67:0] e;
    bus_rd(8'h34, d); check("R1 word0 after reset", 68'(d), 68'h0);
    bus_rd(8'h38, d); check("R1 word1 after reset", 68'(d), 68'h0);
    bus_rd(8'h3C, d); check("R1 word2 after reset", 68'(d), 68'h0);
    eng_rd(0, e);       check("R1 entry 0 free", e, 68'h0);
    eng_rd(DEPTH-1, e); check("R1 last entry free", e, 68'h0);
  endtask

  task automatic t_stage;
    logic [31:0] d;
    bus_wr(8'h34, 32'hFFFFFFFF); bus_rd(8'h34, d);
    check("R2 word0 keeps 4 bits", 68'(d), 68'h0000000F);
    bus_wr(8'h38, 32'hDEADBEEF); bus_rd(8'h38, d);
    check("R2 word1 readback", 68'(d), 68'hDEADBEEF);
    bus_wr(8'h3C, 32'h0BADF00D); bus_rd(8'h3C, d);
    check("R2 word2 readback", 68'(d), 68'h0BADF00D);
  endtask

  task automatic t_commit;
    logic [67:0] e;
    bus_wr(8'h34, 32'h0000000A);
    bus_wr(8'h38, 32'h12345678);
    bus_wr(8'h3C, 32'h9ABCDEF0);
    bus_wr(8'h20, 32'h80000005);
    eng_rd(5, e); check("R3 commit word order", e, 68'hA_12345678_9ABCDEF0);
    eng_rd(4, e); check("R8 neighbour 4 untouched", e, 68'h0);
    eng_rd(6, e); check("R8 neighbour 6 untouched", e, 68'h0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    eng_wr(9, 68'h6_CAFEF00D_01234567);
    bus_wr(8'h20, 32'h00000009);
    bus_rd(8'h34, d); check("R4 load word0", 68'(d), 68'h6);
    bus_rd(8'h38, d); check("R4 load word1", 68'(d), 68'hCAFEF00D);
    bus_rd(8'h3C, d); check("R4 load word2", 68'(d), 68'h01234567);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    logic [67:0] e;
    // port 2, blocked 0, secure 1, ucast type 0, entry type 3, VLAN 0x123, MAC 01:02:03:04:05:06
    e = {2'd2, 1'b0, 1'b1, 2'd0, 2'd3, 12'h123, 48'h010203040506};
    eng_wr(12, e);
    bus_wr(8'h20, 32'h0000000C);
    bus_rd(8'h34, d); check("R5 port/secure in word0", 68'(d), 68'h9);
    bus_rd(8'h38, d); check("R5 type/vlan/mac-hi in word1", 68'(d), 68'h31230102);
    check("R5 multicast flag at word1 bit 8", 68'(d[8]), 68'h1);
    bus_rd(8'h3C, d); check("R5 mac-lo in word2", 68'(d), 68'h03040506);
  endtask

  task automatic t_oob;
    logic [31:0] d; logic [67:0] e;
    bus_wr(8'h34, 32'h00000007);
    bus_wr(8'h38, 32'h55555555);
    bus_wr(8'h3C, 32'hAAAAAAAA);
    bus_wr(8'h20, 32'h80000000 | DEPTH);
    eng_rd(0, e); check("R6 oob commit no wrap to 0", e, 68'h0);
    eng_rd(DEPTH, e); check("R6 oob engine read zero", e, 68'h0);
    eng_wr(DEPTH, 68'hF_FFFFFFFF_FFFFFFFF);
    eng_rd(0, e); check("R6 oob engine write ignored", e, 68'h0);
    bus_wr(8'h20, DEPTH + 3);
    bus_rd(8'h34, d); check("R6 oob load word0 zero", 68'(d), 68'h0);
    bus_rd(8'h38, d); check("R6 oob load word1 zero", 68'(d), 68'h0);
    bus_rd(8'h3C, d); check("R6 oob load word2 zero", 68'(d), 68'h0);
  endtask

  task automatic t_arb;
    logic [67:0] e;
    bus_wr(8'h34, 32'h00000003);
    bus_wr(8'h38, 32'h11111111);
    bus_wr(8'h3C, 32'h22222222);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'h80000007;
    eng_req = 1; eng_we = 1; eng_idx = 7'd8; eng_wentry = 68'hC_33333333_44444444;
    #1 check("R7 ready low on collision", 68'(reg_ready), 68'h0);
    @(posedge clk);
    @(negedge clk);
    eng_req = 0; eng_we = 0;
    #1 check("R7 ready high once engine idle", 68'(reg_ready), 68'h1);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
    eng_rd(8, e); check("R7 engine write served", e, 68'hC_33333333_44444444);
    eng_rd(7, e); check("R7 stalled bus commit completes", e, 68'h3_11111111_22222222);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_wr(8'h24, 32'hFFFFFFFF);
    bus_rd(8'h24, d); check("R8 unmapped read zero", 68'(d), 68'h0);
    bus_rd(8'h20, d); check("R8 control reads zero", 68'(d), 68'h0);
    bus_rd(8'h38, d); check("R8 word1 unchanged", 68'(d), 68'h11111111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_stage;
    t_commit;
    t_load;
    t_fields;
    t_oob;
    t_arb;
    t_unmapped;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired got running exp done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule